// File: doc/BRIEF.md
# Cache-Block Operation Ordering Queue

This block sits beside a core's load/store unit and keeps memory operations that write or manage cache blocks in program order. It accepts ordinary stores, block-zero stores, three block maintenance verbs (clean, invalidate, flush), prefetch hints and two kinds of fence. Each accepted entry holds its type and the number of the naturally aligned block it touches. Entries leave strictly from the head over a valid/ready interface toward the memory side. Fence entries never leave on that interface: they drop out by themselves once they reach the head.

Each cycle the queue also answers one question for the load pipeline: may the load now presented issue past the entries still pending? A load waits while any pending maintenance entry names its block. It also waits while a write-ordering fence still has an older store, zero or maintenance entry ahead of it. Stores, zeros and prefetches never hold a load back. Prefetch hints are not ordered at all: no fence waits for them, and the queue drops them outright when it is nearly full. An elaboration option presents clean and invalidate to the memory side as flush, which software cannot tell apart.

Top module: `cbq_order_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `mem_valid` is 0, and `ld_grant` equals `ld_valid`.
- R2: Entries that are not fences and not dropped appear on `mem_op`/`mem_addr` in allocation order. `mem_addr` is the block address with the low log2(BLOCK_BYTES) bits zero. The op codes are STORE=0, ZERO=1, CLEAN=2, INVAL=3, FLUSH=4, PREFETCH=5, FENCE_W=6, FENCE_R=7.
- R3: `alloc_ready` is 0 exactly when DEPTH entries (default 8) are pending. An `alloc_valid` seen while `alloc_ready` is 0 is ignored.
- R4: A load whose address has the same block number (address above the offset bits, 64-byte blocks by default) as any pending CLEAN, INVAL or FLUSH entry gets `ld_grant`=0. The load stays blocked until the cycle after that entry's handshake.
- R5: A load that overlaps only pending STORE, ZERO or PREFETCH entries, or no entry, gets `ld_grant`=1 when no fence holds it back.
- R6: While a pending FENCE_W entry has an older pending STORE, ZERO, CLEAN, INVAL or FLUSH entry ahead of it, every load gets `ld_grant`=0. Older PREFETCH entries do not count.
- R7: FENCE_W and FENCE_R entries never raise `mem_valid`. At the head they leave one cycle later whatever `mem_ready` is. A FENCE_R entry never blocks a load.
- R8: A PREFETCH accepted while PF_LIMIT (default 6) or more entries are pending is discarded and never reaches the memory side.
- R9: With MAINT_AS_FLUSH=1, CLEAN and INVAL entries are presented with `mem_op`=FLUSH (4). All other ops are passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | New entry offered in program order |
| alloc_op | input | 3 | Type of the offered entry |
| alloc_addr | input | AW | Byte address of the offered entry |
| alloc_ready | output | 1 | A free slot exists |
| ld_valid | input | 1 | A younger load asks to issue |
| ld_addr | input | AW | Byte address of that load |
| ld_grant | output | 1 | The load may issue this cycle |
| mem_valid | output | 1 | Head entry offered to the memory side |
| mem_op | output | 3 | Op of the offered entry |
| mem_addr | output | AW | Block-aligned address of the offered entry |
| mem_ready | input | 1 | Memory side takes the offered entry |

## Verification
Allocation and retirement take effect at the clock edge where the handshake is seen, so a new head, the freed slot and the changed load answer are all visible in the next cycle. `ld_grant`, `alloc_ready` and the `mem_*` outputs follow from the registered queue and the present inputs in the same cycle. The bench drives inputs on the falling edge and samples one time unit later, against a program-order model. It advances that model only at the rising edge: the head is removed first, then any new entry is appended. Fence-at-head removal and prefetch dropping are judged on the occupancy before that edge, the same way the queue judges them.

// File: rtl/cbq_pkg.sv
package cbq_pkg;

  typedef enum logic [2:0] {
    OP_STORE   = 3'd0,
    OP_ZERO    = 3'd1,
    OP_CLEAN   = 3'd2,
    OP_INVAL   = 3'd3,
    OP_FLUSH   = 3'd4,
    OP_PREF    = 3'd5,
    OP_FENCE_W = 3'd6,
    OP_FENCE_R = 3'd7
  } cbq_op_e;

  // block maintenance verbs: behave as stores and fence overlapping loads
  function automatic logic op_is_maint(input cbq_op_e op);
    return (op == OP_CLEAN) || (op == OP_INVAL) || (op == OP_FLUSH);
  endfunction

  // everything a write-ordering fence must wait for
  function automatic logic op_is_write(input cbq_op_e op);
    return (op == OP_STORE) || (op == OP_ZERO) || op_is_maint(op);
  endfunction

  function automatic logic op_is_fence(input cbq_op_e op);
    return (op == OP_FENCE_W) || (op == OP_FENCE_R);
  endfunction

endpackage

// File: rtl/cbq_store.sv
module cbq_store
  import cbq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BW    = 26,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  cbq_op_e                    push_op,
  input  logic [BW-1:0]              push_blk,
  input  logic                       pop,
  output logic [DEPTH-1:0]           vld,
  output cbq_op_e [DEPTH-1:0]        ops,
  output logic [DEPTH-1:0][BW-1:0]   blks,
  output logic [PW-1:0]              head,
  output logic [PW:0]                count
);

  logic [PW-1:0] tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (pop) begin
        vld[head] <= 1'b0;
        head      <= head + PW'(1);
      end
      if (push) begin
        vld[tail] <= 1'b1;
        tail      <= tail + PW'(1);
      end
      count <= count + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  // payload has no reset, written only at the tail
  always_ff @(posedge clk) begin
    if (push) begin
      ops[tail]  <= push_op;
      blks[tail] <= push_blk;
    end
  end

endmodule

// File: rtl/cbq_load_gate.sv
module cbq_load_gate
  import cbq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BW    = 26,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]           vld,
  input  cbq_op_e [DEPTH-1:0]        ops,
  input  logic [DEPTH-1:0][BW-1:0]   blks,
  input  logic [PW-1:0]              head,
  input  logic                       ld_valid,
  input  logic [BW-1:0]              ld_blk,
  output logic                       ld_grant
);

  logic [DEPTH-1:0]          hit;
  logic [DEPTH-1:0]          fence_hold;
  logic [DEPTH-1:0][PW-1:0]  age;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign age[i] = PW'(i) - head;
      assign hit[i] = vld[i] && op_is_maint(ops[i]) && (blks[i] == ld_blk);

      always_comb begin
        fence_hold[i] = 1'b0;
        if (vld[i] && ops[i] == OP_FENCE_W) begin
          for (int j = 0; j < DEPTH; j++) begin
            if (vld[j] && op_is_write(ops[j]) && (age[j] < age[i]))
              fence_hold[i] = 1'b1;
          end
        end
      end
    end
  endgenerate

  assign ld_grant = ld_valid && !(|hit) && !(|fence_hold);

endmodule

// File: rtl/cbq_retire.sv
module cbq_retire
  import cbq_pkg::*;
#(
  parameter int AW             = 32,
  parameter int OFF            = 6,
  parameter bit MAINT_AS_FLUSH = 1'b0,
  localparam int BW            = AW - OFF
) (
  input  logic          head_vld,
  input  cbq_op_e       head_op,
  input  logic [BW-1:0] head_blk,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic [2:0]    mem_op,
  output logic [AW-1:0] mem_addr,
  output logic          pop
);

  logic is_fence;
  assign is_fence  = op_is_fence(head_op);
  assign mem_valid = head_vld && !is_fence;
  assign pop       = head_vld && (is_fence || mem_ready);
  assign mem_addr  = {head_blk, {OFF{1'b0}}};

  generate
    if (MAINT_AS_FLUSH) begin : g_fold
      assign mem_op = ((head_op == OP_CLEAN) || (head_op == OP_INVAL)) ? OP_FLUSH : head_op;
    end else begin : g_pass
      assign mem_op = head_op;
    end
  endgenerate

endmodule

// File: rtl/cbq_order_queue.sv
module cbq_order_queue
  import cbq_pkg::*;
#(
  parameter int AW             = 32,
  parameter int BLOCK_BYTES    = 64,
  parameter int DEPTH          = 8,
  parameter int PF_LIMIT       = 6,
  parameter bit MAINT_AS_FLUSH = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_valid,
  input  logic [2:0]    alloc_op,
  input  logic [AW-1:0] alloc_addr,
  output logic          alloc_ready,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_grant,
  output logic          mem_valid,
  output logic [2:0]    mem_op,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready
);

  localparam int OFF = $clog2(BLOCK_BYTES);
  localparam int BW  = AW - OFF;
  localparam int PW  = $clog2(DEPTH);

  logic [DEPTH-1:0]          vld;
  cbq_op_e [DEPTH-1:0]       ops;
  logic [DEPTH-1:0][BW-1:0]  blks;
  logic [PW-1:0]             head;
  logic [PW:0]               count;
  logic                      accept, drop, push, pop;
  cbq_op_e                   in_op;

  assign in_op       = cbq_op_e'(alloc_op);
  assign alloc_ready = (count < (PW+1)'(DEPTH));
  assign accept      = alloc_valid && alloc_ready;
  assign drop        = (in_op == OP_PREF) && (count >= (PW+1)'(PF_LIMIT));
  assign push        = accept && !drop;

  cbq_store #(.DEPTH(DEPTH), .BW(BW)) u_store (
    .clk(clk), .rst(rst),
    .push(push), .push_op(in_op), .push_blk(alloc_addr[AW-1:OFF]),
    .pop(pop),
    .vld(vld), .ops(ops), .blks(blks), .head(head), .count(count)
  );

  cbq_load_gate #(.DEPTH(DEPTH), .BW(BW)) u_gate (
    .vld(vld), .ops(ops), .blks(blks), .head(head),
    .ld_valid(ld_valid), .ld_blk(ld_addr[AW-1:OFF]),
    .ld_grant(ld_grant)
  );

  cbq_retire #(.AW(AW), .OFF(OFF), .MAINT_AS_FLUSH(MAINT_AS_FLUSH)) u_retire (
    .head_vld(vld[head]), .head_op(ops[head]), .head_blk(blks[head]),
    .mem_ready(mem_ready),
    .mem_valid(mem_valid), .mem_op(mem_op), .mem_addr(mem_addr),
    .pop(pop)
  );

endmodule

// File: rtl/cbq_order_queue_chk.sv
module cbq_order_queue_chk #(
  parameter int AW          = 32,
  parameter int BLOCK_BYTES = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic          ld_valid,
  input logic          ld_grant,
  input logic          mem_valid,
  input logic [2:0]    mem_op,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready
);

  localparam int OFF = $clog2(BLOCK_BYTES);

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (alloc_ready && !mem_valid));

  assert_hold_offer_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_op)));

  assert_block_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[OFF-1:0] == '0));

  assert_no_fence_out_R7: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_op < 3'd6));

  assert_grant_needs_load_R5: assert property (@(posedge clk) disable iff (rst)
    ld_grant |-> ld_valid);

endmodule

bind cbq_order_queue cbq_order_queue_chk #(.AW(AW), .BLOCK_BYTES(BLOCK_BYTES)) u_chk (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .ld_valid(ld_valid), .ld_grant(ld_grant), .mem_valid(mem_valid),
  .mem_op(mem_op), .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/cbq_order_queue_bench.sv
module cbq_order_queue_bench;

  localparam int AW = 32;
  localparam int OFF = 6;
  localparam int DEPTH = 8;
  localparam int PF_LIMIT = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alloc_valid = 1'b0;
  logic [2:0]    alloc_op = 3'd0;
  logic [AW-1:0] alloc_addr = '0;
  logic          ld_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic          mem_ready = 1'b0;
  logic          alloc_ready, ld_grant, mem_valid;
  logic [2:0]    mem_op;
  logic [AW-1:0] mem_addr;
  logic          f_alloc_ready, f_ld_grant, f_mem_valid;
  logic [2:0]    f_mem_op;
  logic [AW-1:0] f_mem_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // program-order model, oldest at index 0
  int m_op[DEPTH];
  int m_blk[DEPTH];
  int m_cnt = 0;

  always #4 clk = ~clk;

  cbq_order_queue u_cbq_order_queue (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_op(alloc_op),
    .alloc_addr(alloc_addr), .alloc_ready(alloc_ready), .ld_valid(ld_valid),
    .ld_addr(ld_addr), .ld_grant(ld_grant), .mem_valid(mem_valid),
    .mem_op(mem_op), .mem_addr(mem_addr), .mem_ready(mem_ready)
  );

  cbq_order_queue #(.MAINT_AS_FLUSH(1'b1)) u_cbq_order_queue_flush (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_op(alloc_op),
    .alloc_addr(alloc_addr), .alloc_ready(f_alloc_ready), .ld_valid(ld_valid),
    .ld_addr(ld_addr), .ld_grant(f_ld_grant), .mem_valid(f_mem_valid),
    .mem_op(f_mem_op), .mem_addr(f_mem_addr), .mem_ready(mem_ready)
  );

  function automatic bit is_maint(int op);
    return op == 2 || op == 3 || op == 4;
  endfunction

  function automatic bit is_write(int op);
    return op <= 4;
  endfunction

  function automatic bit hit_maint(int blk);
    for (int i = 0; i < m_cnt; i++)
      if (is_maint(m_op[i]) && m_blk[i] == blk) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit fence_blocks();
    bit seen_w = 1'b0;
    for (int i = 0; i < m_cnt; i++) begin
      if (m_op[i] == 6 && seen_w) return 1'b1;
      if (is_write(m_op[i])) seen_w = 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare, advance model at rising edge
  task automatic step(bit av, int op, int blk, int offs, bit lv, int lblk, bit mr, string tag);
    bit exp_ready, acc, drop, head_fence, pop, exp_mv, exp_grant, hm, fb;
    int exp_op, fold_op;
    @(negedge clk);
    alloc_valid = av;
    alloc_op    = 3'(op);
    alloc_addr  = AW'(blk) << OFF | AW'(offs);
    ld_valid    = lv;
    ld_addr     = AW'(lblk) << OFF | AW'(offs);
    mem_ready   = mr;
    #1;
    exp_ready  = m_cnt < DEPTH;
    acc        = av && exp_ready;
    drop       = acc && op == 5 && m_cnt >= PF_LIMIT;
    head_fence = m_cnt > 0 && m_op[0] >= 6;
    exp_mv     = m_cnt > 0 && !head_fence;
    pop        = m_cnt > 0 && (head_fence || mr);
    hm         = hit_maint(lblk);
    fb         = fence_blocks();
    exp_grant  = lv && !hm && !fb;
    check(alloc_ready == exp_ready, "R3 alloc_ready", alloc_ready, exp_ready);
    check(mem_valid == exp_mv, head_fence ? "R7 fence never offered" : {tag, " mem_valid"},
          mem_valid, exp_mv);
    if (exp_mv) begin
      exp_op  = m_op[0];
      fold_op = (exp_op == 2 || exp_op == 3) ? 4 : exp_op;
      check(mem_op == 3'(exp_op), {tag, " mem_op order"}, mem_op, exp_op);
      check(mem_addr == (AW'(m_blk[0]) << OFF), {tag, " mem_addr aligned"}, mem_addr,
            AW'(m_blk[0]) << OFF);
      check(f_mem_op == 3'(fold_op), "R9 folded op", f_mem_op, fold_op);
    end
    check(ld_grant == exp_grant, hm ? "R4 maint overlap" : (fb ? "R6 fence hold" : "R5 load pass"),
          ld_grant, exp_grant);
    @(posedge clk);
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        m_op[i] = m_op[i+1];
        m_blk[i] = m_blk[i+1];
      end
      m_cnt--;
    end
    if (acc && !drop) begin
      m_op[m_cnt] = op;
      m_blk[m_cnt] = blk;
      m_cnt++;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(alloc_ready == 1'b1, "R1 ready after reset", alloc_ready, 1);
    check(mem_valid == 1'b0, "R1 empty after reset", mem_valid, 0);
    ld_valid = 1'b1;
    #1;
    check(ld_grant == 1'b1, "R1 load free after reset", ld_grant, 1);

    // R3: fill with stores, no draining, extra offers ignored
    for (int k = 0; k < DEPTH + 2; k++) step(1, 0, 10 + k, 4, 1, 10, 0, "R3");
    // R8: drain two, then a prefetch at occupancy 6 is dropped
    step(0, 0, 0, 0, 0, 0, 1, "R2");
    step(0, 0, 0, 0, 0, 0, 1, "R2");
    step(1, 5, 40, 0, 0, 0, 0, "R8");
    for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 1, 40, 1, "R8");

    // R4/R5: pending clean blocks its block only until retirement
    step(1, 2, 5, 0, 0, 0, 0, "R4");
    step(1, 0, 6, 0, 1, 5, 0, "R4");
    step(0, 0, 0, 0, 1, 6, 0, "R5");
    step(0, 0, 0, 9, 1, 5, 1, "R4");
    step(0, 0, 0, 0, 1, 5, 1, "R4");
    step(0, 0, 0, 0, 1, 5, 0, "R5");

    // R6/R7: fence after prefetch holds nothing; after a store it holds loads
    step(1, 5, 7, 0, 0, 0, 0, "R6");
    step(1, 6, 0, 0, 1, 3, 0, "R6");
    step(1, 7, 0, 0, 1, 3, 0, "R7");
    step(1, 0, 8, 0, 1, 3, 0, "R6");
    step(1, 6, 0, 0, 1, 3, 0, "R6");
    for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 1, 3, 1, "R7");

    // constrained random mix over four blocks
    for (int k = 0; k < 4000; k++) begin
      step($urandom_range(0, 99) < 60, $urandom_range(0, 7), 20 + $urandom_range(0, 3),
           $urandom_range(0, 63), $urandom_range(0, 1), 20 + $urandom_range(0, 3),
           $urandom_range(0, 99) < ((k / 500) % 2 == 0 ? 70 : 25), "R2");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule